// File: doc/BRIEF.md
# Stream Cipher Session Controller

This block runs a complete cipher session around a generic feedback-shift-register keystream generator. After reset it accepts the key and then the IV as fixed-width words on one shared load port. Each word is shifted straight into the generator state, so there is no separate key or IV storage. When the last word arrives the block runs a fixed number of initialization cycles. During these cycles the keystream is folded back into the register and is not emitted. The block then streams data: each accepted plaintext (or ciphertext) word is XORed with keystream and returned one cycle later with a valid strobe. XOR is its own inverse, so the same path encrypts and decrypts.

Three flags gate the phases: load-ready, data-ready, and the output-valid strobe. The load word width always equals the data width. A direction select is captured with the first key word and folded into the generator state. A decimated variant, chosen by parameter, runs the generator every cycle but offers only one data bit in every four cycles.

Top module: `strm_cipher_ctl`

## Requirements
- R1: In the cycle after a synchronous reset, `ld_rdy` is 1 and `pt_rdy` and `ct_vld` are 0. The generator state is all ones.
- R2: A load word is taken only on a cycle with `ld_wr`=1 and `ld_rdy`=1. Exactly LOAD_WORDS=(KEY_BITS+IV_BITS)/DW words are taken, because the IV is always loaded at full length. After loading, the state is {ones in bits SW-1 down to KEY_BITS+IV_BITS+1, dir in bit KEY_BITS+IV_BITS, key, iv}, and word 0 supplies the most significant DW bits of {key,iv}.
- R3: `ld_rdy` falls in the cycle after the last load word is taken and stays 0 until reset. After that, `ld_wr` has no effect.
- R4: `dir_sel` is sampled only on the cycle the first load word is taken. Its value on any later cycle has no effect.
- R5: Initialization starts automatically and runs for INIT_CYC cycles. Each of these cycles performs DW generator steps with the keystream bit XORed into the feedback bit. `ct_vld` stays 0 throughout. In normal mode, `pt_rdy` rises exactly INIT_CYC cycles after `ld_rdy` falls.
- R6: One generator step works on state S as follows. z = S[SW-1]^S[TAP_Z] and f = S[SW-1]^S[TAP_A]^(S[TAP_B]&S[TAP_C]). The next state is {S[SW-2:0], f}. During initialization, f is replaced by f^z.
- R7: In normal mode, `pt_rdy` stays 1 once it has risen. Each word taken (`pt_wr`=1) is XORed with a keystream word whose bit i is the z of step i, and the generator then advances DW steps. The generator does not advance on idle cycles.
- R8: `pt_wr` while `pt_rdy`=0 is ignored. It produces no `ct_vld`, and it neither advances nor alters the keystream.
- R9: In decimated mode (DECIM=1, DW=1), the generator steps once on every streaming cycle. `pt_rdy` is 1 on one cycle in four, first INIT_CYC+3 cycles after `ld_rdy` falls. The bit taken in the k-th window is XORed with the z of the state after 3+4k streaming steps.
- R10: `ct_vld` is 1 exactly on the cycle after a data word is taken, and 0 on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_sel | input | 1 | Direction select (1 encrypt, 0 decrypt), captured with the first load word |
| ld_wr | input | 1 | Load word strobe |
| ld_word | input | DW | Key/IV word |
| ld_rdy | output | 1 | Block accepts load words |
| pt_wr | input | 1 | Data word strobe |
| pt_word | input | DW | Input data word |
| pt_rdy | output | 1 | Block accepts a data word this cycle |
| ct_word | output | DW | Output data word (input XOR keystream) |
| ct_vld | output | 1 | Output word valid |

## Verification
The bench builds two instances. The first uses the default parameters: an 8-bit word, a 160-bit state, an 80-bit key, a 64-bit IV and 320 initialization cycles. This instance exercises the full-length initialization, word-wide keystream unrolling, direction capture, and idle gaps within both the load and stream phases. The second instance is the decimated variant with a 1-bit word and 96 initialization cycles. It reaches the one-in-four readiness spacing, the free-running generator, and a 144-word bit-serial load in a short run. An independent bench model of the generator steps predicts every output word.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    PH_LOAD   = 2'd0,
    PH_INIT   = 2'd1,
    PH_STREAM = 2'd2
  } sc_phase_e;
endpackage

// File: rtl/sc_kfsr_core.sv
module sc_kfsr_core #(
  parameter int SW    = 160,
  parameter int DW    = 8,
  parameter int TAP_A = 97,
  parameter int TAP_B = 45,
  parameter int TAP_C = 46,
  parameter int TAP_Z = 120
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic          load_first,
  input  logic          dir,
  input  logic [DW-1:0] load_word,
  input  logic          init_en,
  input  logic          run_en,
  output logic [DW-1:0] ks_o
);
  logic [SW-1:0] state;
  logic [SW-1:0] chain [DW+1];
  logic          low_bit;

  assign chain[0] = state;

  // Unrolled generator: DW steps per clock, bit g of the keystream word from step g
  for (genvar g = 0; g < DW; g++) begin : g_step
    logic zb;
    logic fb;
    assign zb = chain[g][SW-1] ^ chain[g][TAP_Z];
    assign fb = chain[g][SW-1] ^ chain[g][TAP_A]
              ^ (chain[g][TAP_B] & chain[g][TAP_C])
              ^ (init_en & zb);
    assign chain[g+1] = {chain[g][SW-2:0], fb};
    assign ks_o[g]    = zb;
  end

  // Direction is folded into the bit that ends up just above key and IV
  assign low_bit = load_first ? dir : state[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= '1;
    end else if (load_en) begin
      state <= {state[SW-DW-1:1], low_bit, load_word};
    end else if (init_en || run_en) begin
      state <= chain[DW];
    end
  end

  // R2: a taken word lands in the low bits of the state
  a_r2_word_lands: assert property (@(posedge clk) disable iff (rst)
    load_en |=> state[DW-1:0] == $past(load_word));

  // R6: a plain streaming advance shifts the state by DW positions
  a_r6_shift_by_word: assert property (@(posedge clk) disable iff (rst)
    (run_en && !init_en && !load_en) |=> state[SW-1:DW] == $past(state[SW-DW-1:0]));
endmodule

// File: rtl/sc_phase_ctrl.sv
module sc_phase_ctrl
  import sc_pkg::*;
#(
  parameter int LOAD_WORDS = 18,
  parameter int INIT_CYC   = 320,
  parameter bit DECIM      = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic ld_wr,
  input  logic pt_wr,
  output logic ld_rdy,
  output logic pt_rdy,
  output logic ld_take,
  output logic ld_first,
  output logic init_run,
  output logic gen_run,
  output logic pt_take
);
  localparam int WCW = $clog2(LOAD_WORDS + 1);
  localparam int ICW = $clog2(INIT_CYC + 1);

  sc_phase_e      phase;
  logic [WCW-1:0] wcnt;
  logic [ICW-1:0] icnt;
  logic           in_stream;

  assign ld_rdy    = (phase == PH_LOAD);
  assign ld_take   = ld_rdy && ld_wr;
  assign ld_first  = (wcnt == '0);
  assign init_run  = (phase == PH_INIT);
  assign in_stream = (phase == PH_STREAM);
  assign pt_take   = pt_rdy && pt_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_LOAD;
      wcnt  <= '0;
      icnt  <= '0;
    end else begin
      case (phase)
        PH_LOAD: if (ld_take) begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == WCW'(LOAD_WORDS - 1)) phase <= PH_INIT;
        end
        PH_INIT: begin
          icnt <= icnt + 1'b1;
          if (icnt == ICW'(INIT_CYC - 1)) phase <= PH_STREAM;
        end
        default: ;
      endcase
    end
  end

  if (DECIM) begin : g_decim
    logic [1:0] dcnt;
    always_ff @(posedge clk) begin
      if (rst)            dcnt <= '0;
      else if (in_stream) dcnt <= dcnt + 1'b1;
    end
    assign pt_rdy  = in_stream && (dcnt == 2'd3);
    assign gen_run = in_stream;

    // R9: a data window never lasts two cycles
    a_r9_window_single: assert property (@(posedge clk) disable iff (rst)
      pt_rdy |=> !pt_rdy);
  end else begin : g_full
    assign pt_rdy  = in_stream;
    assign gen_run = pt_take;

    // R7: readiness holds once streaming has begun
    a_r7_rdy_holds: assert property (@(posedge clk) disable iff (rst)
      pt_rdy |=> pt_rdy);
  end

  // R3: once load readiness is gone it does not return without reset
  a_r3_ld_rdy_stays_low: assert property (@(posedge clk) disable iff (rst)
    !ld_rdy |=> !ld_rdy);

  // R2: no more words are taken than the load needs
  a_r2_word_count: assert property (@(posedge clk) disable iff (rst)
    ld_take |-> wcnt < WCW'(LOAD_WORDS));

  // R5: the initialization counter stays inside its window
  a_r5_init_bound: assert property (@(posedge clk) disable iff (rst)
    init_run |-> icnt < ICW'(INIT_CYC));

  // R5: load and data readiness never overlap
  a_r5_rdy_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ld_rdy && pt_rdy));
endmodule

// File: rtl/sc_out_stage.sv
module sc_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [DW-1:0] pt,
  input  logic [DW-1:0] ks,
  output logic [DW-1:0] ct,
  output logic          ct_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ct     <= '0;
      ct_vld <= 1'b0;
    end else begin
      ct_vld <= take;
      if (take) ct <= pt ^ ks;
    end
  end

  // R10: valid only right after a taken word
  a_r10_vld_follows_take: assert property (@(posedge clk) disable iff (rst)
    ct_vld |-> $past(take));

  // R10: every taken word produces a valid cycle
  a_r10_take_gives_vld: assert property (@(posedge clk) disable iff (rst)
    take |=> ct_vld);
endmodule

// File: rtl/strm_cipher_ctl.sv
module strm_cipher_ctl #(
  parameter int SW       = 160,
  parameter int DW       = 8,
  parameter int KEY_BITS = 80,
  parameter int IV_BITS  = 64,
  parameter int INIT_CYC = 320,
  parameter bit DECIM    = 1'b0,
  parameter int TAP_A    = 97,
  parameter int TAP_B    = 45,
  parameter int TAP_C    = 46,
  parameter int TAP_Z    = 120
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_sel,
  input  logic          ld_wr,
  input  logic [DW-1:0] ld_word,
  output logic          ld_rdy,
  input  logic          pt_wr,
  input  logic [DW-1:0] pt_word,
  output logic          pt_rdy,
  output logic [DW-1:0] ct_word,
  output logic          ct_vld
);
  localparam int LOAD_WORDS = (KEY_BITS + IV_BITS) / DW;

  logic          ld_take;
  logic          ld_first;
  logic          init_run;
  logic          gen_run;
  logic          pt_take;
  logic [DW-1:0] ks;

  sc_phase_ctrl #(
    .LOAD_WORDS (LOAD_WORDS),
    .INIT_CYC   (INIT_CYC),
    .DECIM      (DECIM)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ld_wr    (ld_wr),
    .pt_wr    (pt_wr),
    .ld_rdy   (ld_rdy),
    .pt_rdy   (pt_rdy),
    .ld_take  (ld_take),
    .ld_first (ld_first),
    .init_run (init_run),
    .gen_run  (gen_run),
    .pt_take  (pt_take)
  );

  sc_kfsr_core #(
    .SW    (SW),
    .DW    (DW),
    .TAP_A (TAP_A),
    .TAP_B (TAP_B),
    .TAP_C (TAP_C),
    .TAP_Z (TAP_Z)
  ) u_gen (
    .clk        (clk),
    .rst        (rst),
    .load_en    (ld_take),
    .load_first (ld_first),
    .dir        (dir_sel),
    .load_word  (ld_word),
    .init_en    (init_run),
    .run_en     (gen_run),
    .ks_o       (ks)
  );

  sc_out_stage #(
    .DW (DW)
  ) u_out (
    .clk    (clk),
    .rst    (rst),
    .take   (pt_take),
    .pt     (pt_word),
    .ks     (ks),
    .ct     (ct_word),
    .ct_vld (ct_vld)
  );
endmodule

// File: tb/strm_cipher_ctl_tb_top.sv
module strm_cipher_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW     = 160;
  localparam int DWA    = 8;
  localparam int KB     = 80;
  localparam int IVB    = 64;
  localparam int LB     = KB + IVB;
  localparam int PAD    = SW - LB;
  localparam int INIT_A = 320;
  localparam int INIT_B = 96;
  localparam int TAP_A  = 97;
  localparam int TAP_B  = 45;
  localparam int TAP_C  = 46;
  localparam int TAP_Z  = 120;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic           a_dir, a_ldwr, a_ldrdy, a_ptwr, a_ptrdy, a_ctvld;
  logic [DWA-1:0] a_ldw, a_pt, a_ct;
  logic           b_dir, b_ldwr, b_ldrdy, b_ptwr, b_ptrdy, b_ctvld;
  logic [0:0]     b_ldw, b_pt, b_ct;

  strm_cipher_ctl dut_i (
    .clk(clk), .rst(rst), .dir_sel(a_dir), .ld_wr(a_ldwr), .ld_word(a_ldw),
    .ld_rdy(a_ldrdy), .pt_wr(a_ptwr), .pt_word(a_pt), .pt_rdy(a_ptrdy),
    .ct_word(a_ct), .ct_vld(a_ctvld)
  );

  strm_cipher_ctl #(.DW(1), .INIT_CYC(INIT_B), .DECIM(1'b1)) dut_dec_i (
    .clk(clk), .rst(rst), .dir_sel(b_dir), .ld_wr(b_ldwr), .ld_word(b_ldw),
    .ld_rdy(b_ldrdy), .pt_wr(b_ptwr), .pt_word(b_pt), .pt_rdy(b_ptrdy),
    .ct_word(b_ct), .ct_vld(b_ctvld)
  );

  int checks = 0;
  int fails  = 0;
  logic [DWA-1:0] qa[$];
  string          qa_tag[$];
  logic           qb[$];
  logic [SW-1:0]  ma, mb;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Generator model built from R6
  function automatic logic mz(input logic [SW-1:0] s);
    return s[SW-1] ^ s[TAP_Z];
  endfunction

  function automatic logic [SW-1:0] mstep(input logic [SW-1:0] s, input bit fbk);
    logic fb;
    fb = s[SW-1] ^ s[TAP_A] ^ (s[TAP_B] & s[TAP_C]);
    if (fbk) fb = fb ^ mz(s);
    return {s[SW-2:0], fb};
  endfunction

  // Monitors: pop expected words as outputs appear
  always @(negedge clk) begin
    if (!rst && a_ctvld) begin
      if (qa.size() == 0) chk(1'b0, "R8/R10 unexpected valid (wide)", a_ct, 0);
      else begin
        logic [DWA-1:0] e;
        string t;
        e = qa.pop_front();
        t = qa_tag.pop_front();
        chk(a_ct == e, t, a_ct, e);
      end
    end
    if (!rst && b_ctvld) begin
      if (qb.size() == 0) chk(1'b0, "R8/R10 unexpected valid (decimated)", b_ct, 0);
      else begin
        logic e;
        e = qb.pop_front();
        chk(b_ct[0] == e, "R9 decimated output bit", b_ct, e);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    a_dir = 1'b1; a_ldwr = 1'b0; a_ldw = '0; a_ptwr = 1'b0; a_pt = '0;
    b_dir = 1'b1; b_ldwr = 1'b0; b_ldw = '0; b_ptwr = 1'b0; b_pt = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(a_ldrdy == 1'b1, "R1 ld_rdy after reset", a_ldrdy, 1);
    chk(a_ptrdy == 1'b0, "R1 pt_rdy after reset", a_ptrdy, 0);
    chk(a_ctvld == 1'b0, "R1 ct_vld after reset", a_ctvld, 0);
    chk(b_ldrdy == 1'b1, "R1 ld_rdy after reset (decimated)", b_ldrdy, 1);
  endtask

  task automatic run_a(input logic [KB-1:0] key, input logic [IVB-1:0] iv,
                       input logic d0, input logic dlate, input string tag);
    logic [LB-1:0] l;
    int n;
    l = {key, iv};
    do_reset();
    for (int j = 0; j < LB/DWA; j++) begin
      if (j % 4 == 2) begin
        // idle gap: stray data strobe and a changed direction (R4, R8)
        @(negedge clk);
        a_ldwr = 1'b0; a_ptwr = 1'b1; a_pt = 8'h3C; a_dir = ~d0;
      end
      @(negedge clk);
      chk(a_ldrdy == 1'b1, "R2 still loading", a_ldrdy, 1);
      a_dir = (j == 0) ? d0 : dlate;
      a_ldwr = 1'b1;
      a_ptwr = 1'(j % 2);
      a_pt   = 8'(j);
      a_ldw  = l[LB-1-j*DWA -: DWA];
    end
    @(negedge clk);
    a_ldwr = 1'b0;
    chk(a_ldrdy == 1'b0, "R3 ld_rdy falls after last word", a_ldrdy, 0);
    ma = {{(PAD-1){1'b1}}, d0, l};
    repeat (INIT_A*DWA) ma = mstep(ma, 1'b1);
    a_ptwr = 1'b1; a_pt = 8'h99; a_ldwr = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == INIT_A - 4) begin a_ptwr = 1'b0; a_ldwr = 1'b0; end
    end while (!a_ptrdy && n < INIT_A + 20);
    chk(n == INIT_A, "R5 init length", n, INIT_A);
    for (int i = 0; i < 24; i++) begin
      logic [DWA-1:0] p, ks;
      if (i > 0) @(negedge clk);
      chk(a_ptrdy == 1'b1, "R7 ready held", a_ptrdy, 1);
      if (i % 5 == 3) begin
        a_ptwr = 1'b0; a_ldwr = 1'b1; a_ldw = 8'(i*7);
      end else begin
        case (i % 4)
          0: p = 8'(i*29 + 3);
          1: p = 8'h00;
          2: p = 8'hFF;
          default: p = 8'hA5 ^ 8'(i);
        endcase
        a_ldwr = 1'b0; a_ptwr = 1'b1; a_pt = p;
        for (int k = 0; k < DWA; k++) begin
          ks[k] = mz(ma);
          ma = mstep(ma, 1'b0);
        end
        qa.push_back(p ^ ks);
        qa_tag.push_back(tag);
      end
    end
    @(negedge clk);
    a_ptwr = 1'b0; a_ldwr = 1'b0;
    repeat (3) @(negedge clk);
    chk(qa.size() == 0, "R10 every word returned", qa.size(), 0);
    chk(a_ldrdy == 1'b0, "R3 no reload after stream", a_ldrdy, 0);
  endtask

  task automatic run_b(input logic [KB-1:0] key, input logic [IVB-1:0] iv);
    logic [LB-1:0] l;
    int n, gap, win;
    bit seen;
    l = {key, iv};
    do_reset();
    for (int j = 0; j < LB; j++) begin
      @(negedge clk);
      b_ldwr = 1'b1;
      b_ldw  = l[LB-1-j];
    end
    @(negedge clk);
    b_ldwr = 1'b0;
    chk(b_ldrdy == 1'b0, "R3 ld_rdy falls (decimated)", b_ldrdy, 0);
    mb = {{(PAD-1){1'b1}}, 1'b1, l};
    repeat (INIT_B) mb = mstep(mb, 1'b1);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (!b_ptrdy) begin b_ptwr = 1'b1; b_pt = 1'(n); end
    end while (!b_ptrdy && n < INIT_B + 20);
    chk(n == INIT_B + 3, "R9 first window delay", n, INIT_B + 3);
    gap = 0; win = 0; seen = 1'b0;
    for (int c = 0; c < 64; c++) begin
      if (c > 0) @(negedge clk);
      if (b_ptrdy) begin
        logic z, bit_in;
        if (seen) chk(gap == 3, "R9 window spacing", gap + 1, 4);
        seen = 1'b1; gap = 0;
        repeat (3) mb = mstep(mb, 1'b0);
        z  = mz(mb);
        mb = mstep(mb, 1'b0);
        bit_in = 1'((win * 5 + 1) % 3 == 0);
        if (win % 3 == 2) b_ptwr = 1'b0;
        else begin
          b_ptwr = 1'b1; b_pt = bit_in;
          qb.push_back(bit_in ^ z);
        end
        win++;
      end else begin
        gap++;
        b_ptwr = 1'b1; b_pt = 1'(c);
      end
    end
    @(negedge clk);
    b_ptwr = 1'b0;
    repeat (3) @(negedge clk);
    chk(qb.size() == 0, "R10 every bit returned (decimated)", qb.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    run_a(80'h0123_4567_89AB_CDEF_F00D, 64'hDEAD_BEEF_0BAD_CAFE, 1'b1, 1'b1, "R7 encrypt stream");
    run_a(80'h0, 64'h0, 1'b0, 1'b1, "R4 decrypt direction stream");
    run_a(80'hFFFF_0000_FFFF_0000_FFFF, 64'h1, 1'b1, 1'b0, "R2 key/iv placement stream");
    run_b(80'h5A5A_1234_0FF0_9876_C3C3, 64'h7777_0000_ABCD_0001);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule